// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a word buffer that sits between a card-side data stream and a host bus. It holds 16-bit words, 32 of them by default or 16 in the smaller variant. One FIFO serves both directions. On receive, the card side pushes words and the host reads them through its data port. On transmit, the host writes words and the card side pops them.

A single 16-bit configuration word packs a receive threshold, a transmit threshold and one DMA-enable bit per direction. With a direction's DMA disabled, the block raises a level event when its threshold is met: almost-full for receive and almost-empty for transmit. Software then moves words by programmed I/O. With the DMA enable set, that event is replaced by a request line. The request stays high until one frame of words, equal to the threshold, has moved through the host port. A DMA engine can therefore move exactly one frame per request.

Top module: `tfifo_dma`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, the configuration reads 0x0000, both request lines are low and `evt_almost_full` is low.
- R2: Words leave in the order they were accepted, and `level` counts the accepted words still held. Up to DEPTH words can be held, and `full` is high exactly when the level equals DEPTH.
- R3: A push while full and a pop while empty are ignored. The level and the stored words are unchanged, and the ignored action never counts toward a DMA frame.
- R4: The configuration word is decoded as follows. Bit 15 is the receive DMA enable. Bits 12:8 hold the receive threshold minus one. Bit 7 is the transmit DMA enable. Bits 4:0 hold the transmit threshold minus one. Bits 14:13 and 6:5 read back as 0, so writing 0xFFFF reads back 0x9F9F. A write takes effect in the following cycle.
- R5: `evt_almost_full` is high exactly when receive DMA is disabled and the level is at or above the receive threshold.
- R6: `evt_almost_empty` is high exactly when transmit DMA is disabled and the free space (DEPTH minus level) is at or above the transmit threshold.
- R7: With receive DMA enabled, `dma_rx_req` rises one cycle after the level reaches the receive threshold. It stays high until that many successful host reads have happened, and it is low in the cycle after the last one.
- R8: With transmit DMA enabled, `dma_tx_req` rises one cycle after the free space reaches the transmit threshold. It stays high until that many successful host writes have happened, and it is low in the cycle after the last one.
- R9: An effective threshold is the field value plus one, capped at DEPTH. In the 16-word variant, 0x1F1F gives an almost-full event only at 16 words.
- R10: The value 0x1F1F selects programmed I/O with 32-word thresholds. `evt_almost_full` is then high only when the FIFO is full, and `evt_almost_empty` is high only when it is empty.
- R11: Any configuration write aborts a frame in progress. Both request lines are low in the next cycle, and frame counting restarts from zero.
- R12: Writing 0x0000 disables both request lines. Neither request is high in the cycle after such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| host_wr | input | 1 | Host write (push) strobe |
| host_wdata | input | WIDTH | Host write data |
| host_rd | input | 1 | Host read (pop) strobe |
| host_rdata | output | WIDTH | Word at the FIFO head, seen by the host |
| card_push | input | 1 | Card-side push strobe |
| card_wdata | input | WIDTH | Card-side push data |
| card_pop | input | 1 | Card-side pop strobe |
| card_rdata | output | WIDTH | Word at the FIFO head, seen by the card side |
| level | output | $clog2(DEPTH+1) | Number of words held |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| evt_almost_full | output | 1 | Receive threshold event (programmed I/O) |
| evt_almost_empty | output | 1 | Transmit threshold event (programmed I/O) |
| dma_rx_req | output | 1 | Receive frame request |
| dma_tx_req | output | 1 | Transmit frame request |

## Verification
The assertions assume that at most one side pushes and at most one side pops in any cycle. The host and the card never drive the same direction together. They also assume inputs are held low during reset. The stimulus keeps within these limits by driving one strobe per cycle from a single task. Every strobe is released before the next task call. This keeps the frame counts observed at the ports unambiguous. Overflow and underflow are provoked deliberately, but only from one side at a time.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int CFG_W      = 16;
    localparam int THR_FIELD  = 5;
    localparam int RX_EN_BIT  = 15;
    localparam int RX_THR_LSB = 8;
    localparam int TX_EN_BIT  = 7;
    localparam int TX_THR_LSB = 0;

    typedef struct packed {
        logic                 rx_en;
        logic [THR_FIELD-1:0] rx_thr_m1;
        logic                 tx_en;
        logic [THR_FIELD-1:0] tx_thr_m1;
    } buf_cfg_t;

    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;
    localparam int N_DIR  = 2;

    function automatic buf_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        buf_cfg_t c;
        c.rx_en     = w[RX_EN_BIT];
        c.rx_thr_m1 = w[RX_THR_LSB +: THR_FIELD];
        c.tx_en     = w[TX_EN_BIT];
        c.tx_thr_m1 = w[TX_THR_LSB +: THR_FIELD];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input buf_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[RX_EN_BIT]                = c.rx_en;
        w[RX_THR_LSB +: THR_FIELD]  = c.rx_thr_m1;
        w[TX_EN_BIT]                = c.tx_en;
        w[TX_THR_LSB +: THR_FIELD]  = c.tx_thr_m1;
        return w;
    endfunction

endpackage

// File: rtl/tfifo_cfg.sv
module tfifo_cfg
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             rx_en,
    output logic             tx_en,
    output logic [LW-1:0]    rx_thr,
    output logic [LW-1:0]    tx_thr
);

    buf_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_unpack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // field + 1, capped at the depth of the buffer
    function automatic logic [LW-1:0] eff_thr(input logic [THR_FIELD-1:0] f);
        int unsigned t;
        t = int'(f) + 1;
        if (t > DEPTH) t = DEPTH;
        return LW'(t);
    endfunction

    assign rdata  = cfg_pack(cfg_q);
    assign rx_en  = cfg_q.rx_en;
    assign tx_en  = cfg_q.tx_en;
    assign rx_thr = eff_thr(cfg_q.rx_thr_m1);
    assign tx_thr = eff_thr(cfg_q.tx_thr_m1);

endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];

    assign full    = (st_q.cnt == LW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wr = st_q.wr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        if (push_ok && !pop_ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_ok && !push_ok) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[st_q.wr] <= push_data;
        end
    end

    assign head  = mem[st_q.rd];
    assign level = st_q.cnt;

endmodule

// File: rtl/tfifo_req.sv
module tfifo_req #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          en,
    input  logic [LW-1:0] thr,
    input  logic          ready,
    input  logic          moved,
    output logic          req
);

    typedef struct packed {
        logic          req;
        logic [LW-1:0] cnt;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (restart || !en) begin
            fr_d = '0;
        end else if (fr_q.req) begin
            if (moved) begin
                if (fr_q.cnt + 1'b1 == thr) begin
                    fr_d = '0;
                end else begin
                    fr_d.cnt = fr_q.cnt + 1'b1;
                end
            end
        end else if (ready) begin
            fr_d.req = 1'b1;
            fr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign req = fr_q.req;

endmodule

// File: rtl/tfifo_dma.sv
module tfifo_dma
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             card_push,
    input  logic [WIDTH-1:0] card_wdata,
    input  logic             card_pop,
    output logic [WIDTH-1:0] card_rdata,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             evt_almost_full,
    output logic             evt_almost_empty,
    output logic             dma_rx_req,
    output logic             dma_tx_req
);

    logic          rx_en, tx_en;
    logic [LW-1:0] rx_thr, tx_thr;
    logic [LW-1:0] space;
    logic [WIDTH-1:0] head;
    logic          push_ok, pop_ok;

    logic          dir_en    [N_DIR];
    logic [LW-1:0] dir_thr   [N_DIR];
    logic          dir_ready [N_DIR];
    logic          dir_moved [N_DIR];
    logic          dir_req   [N_DIR];

    tfifo_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .rx_en  (rx_en),
        .tx_en  (tx_en),
        .rx_thr (rx_thr),
        .tx_thr (tx_thr)
    );

    tfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (host_wr || card_push),
        .push_data (card_push ? card_wdata : host_wdata),
        .pop_req   (host_rd || card_pop),
        .head      (head),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok)
    );

    assign space = LW'(DEPTH) - level;

    assign dir_en[DIR_RX]    = rx_en;
    assign dir_thr[DIR_RX]   = rx_thr;
    assign dir_ready[DIR_RX] = (level >= rx_thr);
    assign dir_moved[DIR_RX] = pop_ok && host_rd;

    assign dir_en[DIR_TX]    = tx_en;
    assign dir_thr[DIR_TX]   = tx_thr;
    assign dir_ready[DIR_TX] = (space >= tx_thr);
    assign dir_moved[DIR_TX] = push_ok && host_wr;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        tfifo_req #(.DEPTH(DEPTH)) u_req (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (cfg_we),
            .en      (dir_en[d]),
            .thr     (dir_thr[d]),
            .ready   (dir_ready[d]),
            .moved   (dir_moved[d]),
            .req     (dir_req[d])
        );
    end

    assign dma_rx_req       = dir_req[DIR_RX];
    assign dma_tx_req       = dir_req[DIR_TX];
    assign evt_almost_full  = !rx_en && dir_ready[DIR_RX];
    assign evt_almost_empty = !tx_en && dir_ready[DIR_TX];
    assign host_rdata       = head;
    assign card_rdata       = head;

endmodule

// File: rtl/tfifo_dma_chk.sv
module tfifo_dma_chk #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [15:0]   cfg_wdata,
    input logic [15:0]   cfg_rdata,
    input logic          host_wr,
    input logic          host_rd,
    input logic          card_push,
    input logic          card_pop,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          evt_almost_full,
    input logic          evt_almost_empty,
    input logic          dma_rx_req,
    input logic          dma_tx_req
);

    assert_single_pusher_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && card_push) && !(host_rd && card_pop));

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LW'(DEPTH)) && (full == (level == LW'(DEPTH))));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && (host_wr || card_push) && !(host_rd || card_pop)) |=> $stable(level));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((level == '0) && (host_rd || card_pop) && !(host_wr || card_push)) |=> (level == '0));

    assert_afull_pio_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_almost_full |-> !cfg_rdata[15]);

    assert_aempty_pio_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_almost_empty |-> !cfg_rdata[7]);

    assert_rx_req_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> cfg_rdata[15]);

    assert_tx_req_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> cfg_rdata[7]);

    assert_cfg_write_aborts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!dma_rx_req && !dma_tx_req));

    assert_zero_cfg_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_wdata == 16'h0000)) |=> (cfg_rdata == 16'h0000));

endmodule

bind tfifo_dma tfifo_dma_chk #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .cfg_wdata        (cfg_wdata),
    .cfg_rdata        (cfg_rdata),
    .host_wr          (host_wr),
    .host_rd          (host_rd),
    .card_push        (card_push),
    .card_pop         (card_pop),
    .level            (level),
    .full             (full),
    .evt_almost_full  (evt_almost_full),
    .evt_almost_empty (evt_almost_empty),
    .dma_rx_req       (dma_rx_req),
    .dma_tx_req       (dma_tx_req)
);

// File: tb/tfifo_dma_bench.sv
`timescale 1ns/1ps
module tfifo_dma_bench;

    localparam int DEPTH = 32;
    localparam int W     = 16;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int LW16  = $clog2(17);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          cfg_we;
    logic [15:0]   cfg_wdata, cfg_rdata;
    logic          host_wr, host_rd, card_push, card_pop;
    logic [W-1:0]  host_wdata, card_wdata, host_rdata, card_rdata;
    logic [LW-1:0] level;
    logic          full, empty, evt_af, evt_ae, rx_req, tx_req;

    tfifo_dma #(.DEPTH(DEPTH), .WIDTH(W)) u_tfifo_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .card_push(card_push),
        .card_wdata(card_wdata), .card_pop(card_pop), .card_rdata(card_rdata),
        .level(level), .full(full), .empty(empty), .evt_almost_full(evt_af),
        .evt_almost_empty(evt_ae), .dma_rx_req(rx_req), .dma_tx_req(tx_req)
    );

    // small variant
    logic            s_cfg_we, s_push;
    logic [15:0]     s_cfg_wdata, s_cfg_rdata;
    logic [W-1:0]    s_wdata, s_hrd, s_crd;
    logic [LW16-1:0] s_level;
    logic            s_full, s_empty, s_af, s_ae, s_rxr, s_txr;

    tfifo_dma #(.DEPTH(16), .WIDTH(W)) u_tfifo_dma16 (
        .clk(clk), .rst_n(rst_n), .cfg_we(s_cfg_we), .cfg_wdata(s_cfg_wdata),
        .cfg_rdata(s_cfg_rdata), .host_wr(1'b0), .host_wdata('0),
        .host_rd(1'b0), .host_rdata(s_hrd), .card_push(s_push),
        .card_wdata(s_wdata), .card_pop(1'b0), .card_rdata(s_crd),
        .level(s_level), .full(s_full), .empty(s_empty), .evt_almost_full(s_af),
        .evt_almost_empty(s_ae), .dma_rx_req(s_rxr), .dma_tx_req(s_txr)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [15:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic card_in(input logic [W-1:0] v);
        card_push = 1'b1; card_wdata = v;
        if (exp_q.size() < DEPTH) exp_q.push_back(v);
        tick();
        card_push = 1'b0;
    endtask

    task automatic host_in(input logic [W-1:0] v);
        host_wr = 1'b1; host_wdata = v;
        if (exp_q.size() < DEPTH) exp_q.push_back(v);
        tick();
        host_wr = 1'b0;
    endtask

    task automatic host_out();
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic card_out();
        card_pop = 1'b1;
        tick();
        card_pop = 1'b0;
    endtask

    // monitor: compare the head word against the scoreboard on each pop
    always @(negedge clk) begin
        if (rst_n && (host_rd || card_pop) && exp_q.size() > 0) begin
            chk("R2 order", host_rd ? 32'(host_rdata) : 32'(card_rdata), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; host_wr = 0; host_rd = 0;
        card_push = 0; card_pop = 0; host_wdata = 0; card_wdata = 0;
        s_cfg_we = 0; s_cfg_wdata = 0; s_push = 0; s_wdata = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 level", 32'(level), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 cfg", 32'(cfg_rdata), 0);
        chk("R1 reqs", {30'd0, rx_req, tx_req}, 0);
        chk("R1 afull", 32'(evt_af), 0);

        // R4 field layout and readback
        cfg_write(16'hFFFF);
        chk("R4 readback", 32'(cfg_rdata), 32'h9F9F);

        // R10 programmed I/O with 32-word thresholds
        cfg_write(16'h1F1F);
        chk("R10 aempty when empty", 32'(evt_ae), 1);
        for (int i = 0; i < 31; i++) card_in(W'(16'h1000 + i));
        chk("R10 afull at 31", 32'(evt_af), 0);
        chk("R10 aempty at 31", 32'(evt_ae), 0);
        card_in(16'h101F);
        chk("R10 afull at full", 32'(evt_af), 1);
        chk("R2 full", 32'(full), 1);
        card_in(16'hDEAD);
        chk("R3 overflow ignored", 32'(level), 32);
        for (int i = 0; i < 32; i++) host_out();
        chk("R2 level drained", 32'(level), 0);
        host_out();
        chk("R3 underflow ignored", 32'(level), 0);
        card_in(16'hA5A5);
        host_out();
        chk("R3 data intact after underflow", 32'(level), 0);

        // R5 / R6 threshold events, thresholds 4
        cfg_write(16'h0303);
        for (int i = 0; i < 3; i++) card_in(W'(16'h2000 + i));
        chk("R5 afull below thr", 32'(evt_af), 0);
        card_in(16'h2003);
        chk("R5 afull at thr", 32'(evt_af), 1);
        for (int i = 4; i < 28; i++) card_in(W'(16'h2000 + i));
        chk("R6 aempty space 4", 32'(evt_ae), 1);
        card_in(16'h201C);
        chk("R6 aempty space 3", 32'(evt_ae), 0);
        for (int i = 0; i < 29; i++) host_out();
        chk("R2 level", 32'(level), 0);

        // R7 receive DMA frame of 4
        cfg_write(16'h8300);
        for (int i = 0; i < 4; i++) card_in(W'(16'h3000 + i));
        chk("R7 req one cycle late", 32'(rx_req), 0);
        tick();
        chk("R7 req raised", 32'(rx_req), 1);
        chk("R5 afull suppressed", 32'(evt_af), 0);
        card_in(16'h3004);
        card_in(16'h3005);
        for (int i = 0; i < 3; i++) host_out();
        chk("R7 req held mid frame", 32'(rx_req), 1);
        host_out();
        chk("R7 req drops after frame", 32'(rx_req), 0);
        tick();
        chk("R7 no rearm below thr", 32'(rx_req), 0);

        // R11 configuration write restarts the frame
        card_in(16'h3006);
        card_in(16'h3007);
        tick();
        chk("R7 rearm", 32'(rx_req), 1);
        host_out();
        cfg_write(16'h8300);
        chk("R11 abort", 32'(rx_req), 0);
        card_in(16'h3008);
        tick();
        chk("R11 rearm", 32'(rx_req), 1);
        for (int i = 0; i < 3; i++) host_out();
        chk("R11 count restarted", 32'(rx_req), 1);
        host_out();
        chk("R11 frame ends", 32'(rx_req), 0);

        // R12 writing zero kills requests
        for (int i = 0; i < 4; i++) card_in(W'(16'h4000 + i));
        tick();
        chk("R7 req before zero", 32'(rx_req), 1);
        cfg_write(16'h0000);
        chk("R12 reqs low", {30'd0, rx_req, tx_req}, 0);
        chk("R5 afull after zero", 32'(evt_af), 1);
        for (int i = 0; i < 4; i++) host_out();

        // R8 transmit DMA frame of 8
        cfg_write(16'h0087);
        tick();
        chk("R8 req raised", 32'(tx_req), 1);
        chk("R6 aempty suppressed", 32'(evt_ae), 0);
        for (int i = 0; i < 7; i++) host_in(W'(16'h5000 + i));
        chk("R8 req held", 32'(tx_req), 1);
        host_in(16'h5007);
        chk("R8 req drops", 32'(tx_req), 0);
        tick();
        chk("R8 rearm", 32'(tx_req), 1);
        cfg_write(16'h0000);
        chk("R12 tx low", 32'(tx_req), 0);
        for (int i = 0; i < 8; i++) card_out();
        chk("R2 card drain", 32'(level), 0);

        // R9 clamp in 16-word variant
        s_cfg_we = 1'b1; s_cfg_wdata = 16'h1F1F;
        tick();
        s_cfg_we = 1'b0;
        for (int i = 0; i < 15; i++) begin
            s_push = 1'b1; s_wdata = W'(i);
            tick();
        end
        s_push = 1'b0;
        chk("R9 no afull at 15", 32'(s_af), 0);
        s_push = 1'b1;
        tick();
        s_push = 1'b0;
        chk("R9 afull at 16", 32'(s_af), 1);
        chk("R9 full", 32'(s_full), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule